// File: doc/BRIEF.md
# Overflow-Trapping Integer Pipeline Control

This block is the control core of a five-stage in-order integer pipeline: fetch, decode, execute, memory and writeback. It carries a minimal datapath so its control can be seen from outside. That datapath has a sixteen-entry register file, an adder with full operand forwarding, and a store port. When a signed add or subtract overflows in the execute stage, the pipeline takes a precise trap. The faulting instruction's register write is cancelled, so a destination that is also a source keeps its old value. The two younger instructions in decode and fetch are dropped. The next fetch goes to a fixed handler address, and the faulting instruction's PC is latched into an exception-PC register. Instructions older than the faulting one, already in the memory and writeback stages, retire normally.

Instructions are read from an instruction port addressed by the PC. The PC counts in instruction words. Results appear as registered writeback and store strobes. Flushing only clears stage valid bits. The payload registers are left untouched, and a stage that is not valid never raises a register or memory write.

Top module: `ovf_trap_pipe`

## Requirements
- R1: While reset is held, `wb_we`, `mem_we` and `exc_taken` are 0, `imem_addr` equals RESET_PC and `epc` is 0.
- R2: An instruction word has these fields: opcode in bits 31:28, destination in 27:24, first source in 23:20, second source in 19:16 and immediate in 15:0. Opcode 1 is ADD, 2 is SUB, 3 is ADDU, 4 is SUBU and 5 is LI, which loads the sign-extended immediate. Results are written back in program order. Back-to-back dependent instructions see the newest value without stalling.
- R3: ADD traps when both operands have the same sign and the sum's sign differs. SUB traps when the operands' signs differ and the result's sign differs from the first operand's sign.
- R4: ADDU and SUBU wrap modulo 2^DATA_W and never trap.
- R5: A trapping instruction produces no writeback, so its destination keeps the value it had before that instruction.
- R6: The two instructions following a trapping one, in decode and fetch, produce no register write, store or trap.
- R7: When a trap is taken, `exc_taken` is high for exactly one cycle. In that cycle `imem_addr` equals HANDLER_PC and `epc` holds the trapping instruction's PC. `epc` changes only when a trap is taken. With no trap, `imem_addr` advances by one each cycle.
- R8: The two instructions ahead of a trapping one, in the memory and writeback stages, complete their register write or store.
- R9: Opcode 6 (ST) raises `mem_we` with `mem_addr` set to the immediate and `mem_wdata` set to the forwarded second source.
- R10: Opcodes 0 and 7 to 15 behave as no-operations and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| wb_we | output | 1 | Register writeback strobe |
| wb_rd | output | 4 | Writeback destination register |
| wb_data | output | DATA_W | Writeback value |
| mem_we | output | 1 | Store strobe |
| mem_addr | output | MADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| exc_taken | output | 1 | One-cycle pulse when the overflow trap is taken |
| epc | output | PC_W | PC of the last trapping instruction |

## Verification
The hardest situation to reach is a trap that arrives while the pipeline is full on both sides. It needs a retiring load-immediate in writeback, a store in memory, and more overflow-prone instructions and a store right behind the faulting add. The overflowing add also reads its own destination. The stimulus sets this up with an exact instruction sequence that makes those stages full on the trap cycle. The handler then stores the faulting destination and a register that a flushed instruction would have overwritten. This shows at the store port that the squash and the flush left both registers alone. A reference model in the bench runs each program in order and computes every expected writeback, store and trap PC. The design's strobes are then compared against that model.

// File: rtl/ovx_pkg.sv
package ovx_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 4;
  localparam int NREG    = 1 << REG_AW;
  localparam int IMM_W   = 16;
  localparam int OP_W    = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'h1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h2;
  localparam logic [OP_W-1:0] OP_ADDU = 4'h3;
  localparam logic [OP_W-1:0] OP_SUBU = 4'h4;
  localparam logic [OP_W-1:0] OP_LI   = 4'h5;
  localparam logic [OP_W-1:0] OP_ST   = 4'h6;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  typedef struct packed {
    logic wr;   // writes a register
    logic st;   // performs a store
    logic sgn;  // overflow is checked
    logic sub;  // second operand is negated
    logic li;   // result is the immediate
  } ctl_t;

  function automatic ctl_t decode_op(input logic [OP_W-1:0] op);
    ctl_t c;
    c = '0;
    case (op)
      OP_ADD:  begin c.wr = 1'b1; c.sgn = 1'b1; end
      OP_SUB:  begin c.wr = 1'b1; c.sgn = 1'b1; c.sub = 1'b1; end
      OP_ADDU: begin c.wr = 1'b1; end
      OP_SUBU: begin c.wr = 1'b1; c.sub = 1'b1; end
      OP_LI:   begin c.wr = 1'b1; c.li = 1'b1; end
      OP_ST:   begin c.st = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ovx_fetch.sv
module ovx_fetch
  import ovx_pkg::*;
#(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(64)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               redirect,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [PC_W-1:0]    pc,
  output logic               id_valid,
  output logic [INSTR_W-1:0] id_word,
  output logic [PC_W-1:0]    id_pc
);

  logic [PC_W-1:0] pc_q;

  assign pc = pc_q;

  // control: PC and the decode-stage valid bit
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_PC;
      id_valid <= 1'b0;
    end else if (redirect) begin
      pc_q     <= HANDLER_PC;
      id_valid <= 1'b0;
    end else begin
      pc_q     <= pc_q + 1'b1;
      id_valid <= 1'b1;
    end
  end

  // payload: captured every cycle, qualified by id_valid
  always_ff @(posedge clk) begin
    id_word <= imem_rdata;
    id_pc   <= pc_q;
  end

endmodule

// File: rtl/ovx_regfile.sv
module ovx_regfile
  import ovx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr_a,
  input  logic [REG_AW-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // write-through so a value retiring this cycle is seen by decode
  assign rdata_a = (we && waddr == raddr_a) ? wdata : mem[raddr_a];
  assign rdata_b = (we && waddr == raddr_b) ? wdata : mem[raddr_b];

endmodule

// File: rtl/ovx_fwd_mux.sv
module ovx_fwd_mux
  import ovx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [REG_AW-1:0] sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic              m_en,
  input  logic [REG_AW-1:0] m_rd,
  input  logic [DATA_W-1:0] m_val,
  input  logic              w_en,
  input  logic [REG_AW-1:0] w_rd,
  input  logic [DATA_W-1:0] w_val,
  output logic [DATA_W-1:0] val
);

  // the memory stage is younger than writeback, so it wins
  always_comb begin
    if (m_en && m_rd == sel)      val = m_val;
    else if (w_en && w_rd == sel) val = w_val;
    else                          val = rf_val;
  end

endmodule

// File: rtl/ovx_execute.sv
module ovx_execute
  import ovx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  ctl_t              ctl,
  input  logic [REG_AW-1:0] rs1,
  input  logic [REG_AW-1:0] rs2,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              m_en,
  input  logic [REG_AW-1:0] m_rd,
  input  logic [DATA_W-1:0] m_val,
  input  logic              w_en,
  input  logic [REG_AW-1:0] w_rd,
  input  logic [DATA_W-1:0] w_val,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] opb,
  output logic              ovf
);

  localparam int NSRC = 2;
  localparam int MSB  = DATA_W - 1;

  logic [REG_AW-1:0] src_sel [NSRC];
  logic [DATA_W-1:0] src_rf  [NSRC];
  logic [DATA_W-1:0] src_val [NSRC];

  assign src_sel[0] = rs1;
  assign src_sel[1] = rs2;
  assign src_rf[0]  = rf_a;
  assign src_rf[1]  = rf_b;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    ovx_fwd_mux #(.DATA_W(DATA_W)) u_mux (
      .sel    (src_sel[k]),
      .rf_val (src_rf[k]),
      .m_en   (m_en),
      .m_rd   (m_rd),
      .m_val  (m_val),
      .w_en   (w_en),
      .w_rd   (w_rd),
      .w_val  (w_val),
      .val    (src_val[k])
    );
  end

  logic [DATA_W-1:0] a;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;

  assign a     = src_val[0];
  assign opb   = src_val[1];
  assign b_eff = ctl.sub ? ~src_val[1] : src_val[1];
  assign sum   = a + b_eff + DATA_W'(ctl.sub);

  // like-signed inputs giving an opposite-signed result
  assign ovf = ctl.sgn && (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

  assign result = ctl.li ? DATA_W'($signed(imm)) : sum;

endmodule

// File: rtl/ovf_trap_pipe.sv
module ovf_trap_pipe
  import ovx_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              PC_W       = 16,
  parameter int              MADDR_W    = 16,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(64)
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic               wb_we,
  output logic [REG_AW-1:0]  wb_rd,
  output logic [DATA_W-1:0]  wb_data,
  output logic               mem_we,
  output logic [MADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               exc_taken,
  output logic [PC_W-1:0]    epc
);

  // decode stage
  logic               id_valid;
  logic [INSTR_W-1:0] id_word;
  logic [PC_W-1:0]    id_pc;
  instr_t             id_ins;
  ctl_t               id_ctl;
  logic [DATA_W-1:0]  id_a, id_b;
  logic               take_exc;

  ovx_fetch #(
    .PC_W       (PC_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .redirect   (take_exc),
    .imem_rdata (imem_rdata),
    .pc         (imem_addr),
    .id_valid   (id_valid),
    .id_word    (id_word),
    .id_pc      (id_pc)
  );

  assign id_ins = instr_t'(id_word);
  assign id_ctl = decode_op(id_ins.op);

  // writeback stage registers (also the ports)
  logic              wb_we_q;
  logic [REG_AW-1:0] wb_rd_q;
  logic [DATA_W-1:0] wb_data_q;

  ovx_regfile #(.DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .we      (wb_we_q),
    .waddr   (wb_rd_q),
    .wdata   (wb_data_q),
    .raddr_a (id_ins.rs1),
    .raddr_b (id_ins.rs2),
    .rdata_a (id_a),
    .rdata_b (id_b)
  );

  // execute stage registers
  logic              ex_valid;
  ctl_t              ex_ctl;
  logic [REG_AW-1:0] ex_rd, ex_rs1, ex_rs2;
  logic [DATA_W-1:0] ex_a, ex_b;
  logic [IMM_W-1:0]  ex_imm;
  logic [PC_W-1:0]   ex_pc;

  always_ff @(posedge clk) begin
    if (rst) ex_valid <= 1'b0;
    else     ex_valid <= id_valid && !take_exc;
  end

  always_ff @(posedge clk) begin
    ex_ctl <= id_ctl;
    ex_rd  <= id_ins.rd;
    ex_rs1 <= id_ins.rs1;
    ex_rs2 <= id_ins.rs2;
    ex_a   <= id_a;
    ex_b   <= id_b;
    ex_imm <= id_ins.imm;
    ex_pc  <= id_pc;
  end

  // memory stage registers
  logic              m_wr, m_st;
  logic [REG_AW-1:0] m_rd;
  logic [DATA_W-1:0] m_res;
  logic [MADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;

  logic [DATA_W-1:0] ex_res, ex_opb;
  logic              ex_ovf;

  ovx_execute #(.DATA_W(DATA_W)) u_ex (
    .ctl    (ex_ctl),
    .rs1    (ex_rs1),
    .rs2    (ex_rs2),
    .rf_a   (ex_a),
    .rf_b   (ex_b),
    .imm    (ex_imm),
    .m_en   (m_wr),
    .m_rd   (m_rd),
    .m_val  (m_res),
    .w_en   (wb_we_q),
    .w_rd   (wb_rd_q),
    .w_val  (wb_data_q),
    .result (ex_res),
    .opb    (ex_opb),
    .ovf    (ex_ovf)
  );

  assign take_exc = ex_valid && ex_ovf;

  // the trapping instruction enters memory as a bubble
  always_ff @(posedge clk) begin
    if (rst) begin
      m_wr <= 1'b0;
      m_st <= 1'b0;
    end else begin
      m_wr <= ex_valid && ex_ctl.wr && !take_exc;
      m_st <= ex_valid && ex_ctl.st && !take_exc;
    end
  end

  always_ff @(posedge clk) begin
    m_rd    <= ex_rd;
    m_res   <= ex_res;
    m_addr  <= ex_imm[MADDR_W-1:0];
    m_wdata <= ex_opb;
  end

  always_ff @(posedge clk) begin
    if (rst) wb_we_q <= 1'b0;
    else     wb_we_q <= m_wr;
  end

  always_ff @(posedge clk) begin
    wb_rd_q   <= m_rd;
    wb_data_q <= m_res;
  end

  // trap pulse and saved PC
  logic            exc_q;
  logic [PC_W-1:0] epc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q <= 1'b0;
      epc_q <= '0;
    end else begin
      exc_q <= take_exc;
      if (take_exc) epc_q <= ex_pc;
    end
  end

  assign wb_we     = wb_we_q;
  assign wb_rd     = wb_rd_q;
  assign wb_data   = wb_data_q;
  assign mem_we    = m_st;
  assign mem_addr  = m_addr;
  assign mem_wdata = m_wdata;
  assign exc_taken = exc_q;
  assign epc       = epc_q;

endmodule

// File: rtl/ovf_trap_checker.sv
module ovf_trap_checker #(
  parameter int              PC_W       = 16,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] HANDLER_PC = PC_W'(64)
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imem_addr,
  input logic            wb_we,
  input logic            mem_we,
  input logic            exc_taken,
  input logic [PC_W-1:0] epc,
  input logic            ex_valid,
  input logic            ex_sgn
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: quiet outputs while reset has been held across an edge
  always @(posedge clk) begin
    if (rst_q && rst) begin
      p_reset_idle_r1: assert (!wb_we && !mem_we && !exc_taken &&
                               imem_addr == RESET_PC && epc == '0)
        else $error("reset state wrong");
    end
  end

  // R7: trap steers fetch to the handler
  p_redirect_r7: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> imem_addr == HANDLER_PC);

  // R7: single-cycle trap pulse
  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> !exc_taken);

  // R7: saved PC only moves with a trap
  p_epc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(epc) |-> exc_taken);

  // R7: sequential fetch otherwise
  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!exc_taken && !$past(rst)) |-> imem_addr == $past(imem_addr) + 1'b1);

  // R4: only a valid signed operation in execute can cause a trap
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> $past(ex_valid && ex_sgn));

  // R5: the trapping instruction neither stores nor writes back
  p_squash_mem_r5: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> !mem_we);
  p_squash_wb_r5: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> !wb_we);

  // R6: flushed decode and fetch slots stay silent
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> !mem_we);
  p_flush_late_r6: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> ##1 (!wb_we && !mem_we));

endmodule

bind ovf_trap_pipe ovf_trap_checker #(
  .PC_W       (PC_W),
  .RESET_PC   (RESET_PC),
  .HANDLER_PC (HANDLER_PC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .wb_we     (wb_we),
  .mem_we    (mem_we),
  .exc_taken (exc_taken),
  .epc       (epc),
  .ex_valid  (ex_valid),
  .ex_sgn    (ex_ctl.sgn)
);

// File: tb/test_ovf_trap_pipe.sv
module test_ovf_trap_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_N     = 128;
  localparam int HPC        = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        wb_we;
  logic [3:0]  wb_rd;
  logic [15:0] wb_data;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        exc_taken;
  logic [15:0] epc;

  logic [31:0] prog [PROG_N];

  assign imem_rdata = (imem_addr < 16'(PROG_N)) ? prog[imem_addr[6:0]] : 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_trap_pipe i_ovf_trap_pipe (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .exc_taken(exc_taken), .epc(epc)
  );

  int checks = 0;
  int errors = 0;

  logic [19:0] q_wb  [$];
  logic [31:0] q_st  [$];
  logic [15:0] q_exc [$];
  string tag_wb, tag_st, tag_exc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] rd,
                                     input logic [3:0] ra, input logic [3:0] rb,
                                     input logic [15:0] imm);
    return {op, rd, ra, rb, imm};
  endfunction

  // reference model: in-order execution, pushes expected events
  task automatic model();
    logic [15:0] r [16];
    int pc, steps, s;
    for (int i = 0; i < 16; i++) r[i] = '0;
    pc = 0; steps = 0;
    while (pc < PROG_N && steps < 400) begin
      logic [31:0] w;
      logic [3:0]  op, rd, ra, rb;
      logic [15:0] a, b, imm;
      int nxt;
      w = prog[pc]; op = w[31:28]; rd = w[27:24]; ra = w[23:20]; rb = w[19:16];
      imm = w[15:0]; a = r[ra]; b = r[rb]; nxt = pc + 1;
      case (op)
        4'h1, 4'h2: begin
          s = (op == 4'h1) ? int'($signed(a)) + int'($signed(b))
                           : int'($signed(a)) - int'($signed(b));
          if (s > 32767 || s < -32768) begin
            q_exc.push_back(16'(pc));
            nxt = HPC;
          end else begin
            r[rd] = s[15:0];
            q_wb.push_back({rd, s[15:0]});
          end
        end
        4'h3: begin r[rd] = a + b; q_wb.push_back({rd, r[rd]}); end
        4'h4: begin r[rd] = a - b; q_wb.push_back({rd, r[rd]}); end
        4'h5: begin r[rd] = imm;   q_wb.push_back({rd, imm}); end
        4'h6: q_st.push_back({imm, b});
        default: ;
      endcase
      pc = nxt; steps++;
    end
  endtask

  // monitor: compares design events against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (wb_we) begin
        if (q_wb.size() == 0) chk(1'b0, "R6", "unexpected writeback", {12'h0, wb_rd, wb_data}, 32'h0);
        else begin
          logic [19:0] e;
          e = q_wb.pop_front();
          chk({wb_rd, wb_data} == e, tag_wb, "writeback", {12'h0, wb_rd, wb_data}, {12'h0, e});
        end
      end
      if (mem_we) begin
        if (q_st.size() == 0) chk(1'b0, "R6", "unexpected store", {mem_addr, mem_wdata}, 32'h0);
        else begin
          logic [31:0] e;
          e = q_st.pop_front();
          chk({mem_addr, mem_wdata} == e, tag_st, "store", {mem_addr, mem_wdata}, e);
        end
      end
      if (exc_taken) begin
        if (q_exc.size() == 0) chk(1'b0, "R3", "unexpected trap", {16'h0, epc}, 32'h0);
        else begin
          logic [15:0] e;
          e = q_exc.pop_front();
          chk(epc == e, tag_exc, "trap PC", {16'h0, epc}, {16'h0, e});
          chk(imem_addr == 16'(HPC), "R7", "handler fetch", {16'h0, imem_addr}, HPC);
        end
      end
    end
  end

  task automatic run_phase(input string twb, input string tst, input string texc);
    q_wb.delete(); q_st.delete(); q_exc.delete();
    tag_wb = twb; tag_st = tst; tag_exc = texc;
    model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wb_we == 1'b0, "R1", "reset wb_we", {31'h0, wb_we}, 0);
    chk(mem_we == 1'b0, "R1", "reset mem_we", {31'h0, mem_we}, 0);
    chk(exc_taken == 1'b0, "R1", "reset exc_taken", {31'h0, exc_taken}, 0);
    chk(imem_addr == 16'h0, "R1", "reset pc", {16'h0, imem_addr}, 0);
    chk(epc == 16'h0, "R1", "reset epc", {16'h0, epc}, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (220) @(posedge clk);
    @(negedge clk);
    chk(q_wb.size() == 0 && q_st.size() == 0 && q_exc.size() == 0, "R6",
        "events left over", 32'(q_wb.size() + q_st.size() + q_exc.size()), 0);
    @(posedge clk); #1 rst = 1'b1;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < PROG_N; i++) prog[i] = 32'h0;
  endtask

  initial begin
    clear_prog();
    // Phase A (R2, R9, R10): dependent chain, unknown opcodes, stores
    prog[0]  = mk(4'h5, 4'd1, 0, 0, 16'h1234);
    prog[1]  = mk(4'h5, 4'd2, 0, 0, 16'h0101);
    prog[2]  = mk(4'h5, 4'd3, 0, 0, 16'h0F00);
    prog[3]  = mk(4'h1, 4'd5, 4'd1, 4'd2, 0);
    prog[4]  = mk(4'h2, 4'd6, 4'd5, 4'd3, 0);
    prog[5]  = mk(4'h1, 4'd7, 4'd6, 4'd5, 0);
    prog[6]  = mk(4'h3, 4'd8, 4'd7, 4'd7, 0);
    prog[7]  = mk(4'hF, 4'd1, 4'd2, 4'd3, 16'h5555);
    prog[8]  = mk(4'h9, 4'd1, 4'd8, 4'd8, 16'h00AA);
    prog[9]  = mk(4'h6, 0, 0, 4'd8, 16'd10);
    prog[10] = mk(4'h6, 0, 0, 4'd1, 16'd11);
    prog[11] = mk(4'h4, 4'd9, 4'd1, 4'd8, 0);
    prog[12] = mk(4'h6, 0, 0, 4'd9, 16'd12);
    prog[13] = mk(4'h5, 4'd4, 0, 0, 16'hFFFE);
    prog[14] = mk(4'h1, 4'd4, 4'd4, 4'd4, 0);
    run_phase("R2", "R9/R10", "R3");

    // Phase B (R3, R5, R6, R8): ADD traps with full pipe both sides
    clear_prog();
    prog[0]  = mk(4'h5, 4'd1, 0, 0, 16'h7FF0);
    prog[1]  = mk(4'h5, 4'd2, 0, 0, 16'h0020);
    prog[2]  = mk(4'h5, 4'd3, 0, 0, 16'h0005);
    prog[3]  = mk(4'h5, 4'd4, 0, 0, 16'h8000);
    prog[4]  = mk(4'h5, 4'd9, 0, 0, 16'h0ABC);   // in writeback at trap
    prog[5]  = mk(4'h6, 0, 0, 4'd2, 16'd5);      // in memory at trap
    prog[6]  = mk(4'h1, 4'd1, 4'd2, 4'd1, 0);    // traps, r1 keeps 7FF0
    prog[7]  = mk(4'h2, 4'd1, 4'd1, 4'd4, 0);    // flushed
    prog[8]  = mk(4'h6, 0, 0, 4'd1, 16'd7);      // flushed
    prog[9]  = mk(4'h5, 4'd3, 0, 0, 16'h1111);
    prog[64] = mk(4'h6, 0, 0, 4'd1, 16'd20);
    prog[65] = mk(4'h6, 0, 0, 4'd3, 16'd21);
    prog[66] = mk(4'h1, 4'd10, 4'd1, 4'd3, 0);
    prog[67] = mk(4'h6, 0, 0, 4'd10, 16'd22);
    prog[68] = mk(4'h6, 0, 0, 4'd9, 16'd23);
    run_phase("R8", "R5/R6/R8", "R3/R7");

    // Phase C (R3, R4, R5): SUB trap, unsigned wraps never trap
    clear_prog();
    prog[0]  = mk(4'h5, 4'd1, 0, 0, 16'h8000);
    prog[1]  = mk(4'h5, 4'd2, 0, 0, 16'h0001);
    prog[2]  = mk(4'h5, 4'd3, 0, 0, 16'h0042);
    prog[3]  = mk(4'h5, 4'd6, 0, 0, 16'h7FFF);
    prog[4]  = mk(4'h3, 4'd4, 4'd6, 4'd2, 0);
    prog[5]  = mk(4'h4, 4'd5, 4'd1, 4'd2, 0);
    prog[6]  = mk(4'h1, 4'd7, 4'd1, 4'd6, 0);
    prog[7]  = mk(4'h2, 4'd8, 4'd1, 4'd1, 0);
    prog[8]  = mk(4'h6, 0, 0, 4'd4, 16'd1);
    prog[9]  = mk(4'h6, 0, 0, 4'd5, 16'd2);
    prog[10] = mk(4'h2, 4'd3, 4'd1, 4'd2, 0);    // traps, r3 keeps 0042
    prog[11] = mk(4'h5, 4'd3, 0, 0, 16'h9999);
    prog[12] = mk(4'h1, 4'd3, 4'd3, 4'd3, 0);
    prog[64] = mk(4'h6, 0, 0, 4'd3, 16'd30);
    prog[65] = mk(4'h4, 4'd11, 4'd2, 4'd1, 0);
    prog[66] = mk(4'h6, 0, 0, 4'd11, 16'd31);
    prog[67] = mk(4'h6, 0, 0, 4'd7, 16'd32);
    run_phase("R4", "R5", "R3/R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule